// File: doc/BRIEF.md
# Hardware address breakpoint unit

This block watches a stream of access events and raises a debug exception when one of them touches a programmed breakpoint. Each event carries a 32-bit linear address, an access size of one, two or four bytes, and a kind: instruction fetch, data read, data write or I/O. Four breakpoint slots each hold an address together with a length field and an access-type field in a shared control register. An access hits a slot when its byte range overlaps the slot's byte window and its kind is one the slot watches.

Every hit sets a sticky per-slot bit in a status register, whatever the enables say. A slot has a local and a global enable. If either is set, a hit also produces a one-cycle pulse on `dbg_exc`. A task-switch strobe clears the local enables and keeps the global ones. Software reaches the registers through a small indexed read/write port. A guard bit in the control register can lock every register against writes. A locked write is dropped, sets a status bit and raises the exception. Separate strobes from the single-step and task-trap sources only record their causes in the status register.

Top module: `brkpt_watch_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero and `dbg_exc` is low.
- R2: Register index 0 to 3 selects the four breakpoint address registers, which read back all 32 bits. Index 6 is status and index 7 is control. Indices 4 and 5 read zero and writes to them change nothing. Control keeps bits 0-9, bit 13 and bits 16-31, and status keeps bits 0-3 and 13-15. All other bits read zero.
- R3: The length field of slot i is control bits [19+4i:18+4i]. 00 is a one-byte window at the address. 01 is a two-byte window with address bit 0 ignored. 11 is a four-byte window with address bits 1:0 ignored. 10 never matches.
- R4: The type field of slot i is control bits [17+4i:16+4i]. 01 matches data writes only, 10 matches I/O accesses of any direction, and 11 matches data reads and data writes. Event kinds are coded on `ev_kind` as 00 fetch, 01 data read, 10 data write and 11 I/O.
- R5: Type 00 matches only a fetch event. The slot's length must be 00 and the fetch address must equal the slot address exactly.
- R6: `ev_size` 00, 01 and 1x give accesses of 1, 2 and 4 bytes. A data or I/O access hits when any of its bytes falls in the slot window, so an unaligned access that straddles into the window counts. Windows do not wrap past the top of the address space.
- R7: A hit on slot i sets status bit i in the edge that ends the event cycle, with or without enables. Status bits stay set until software writes the status register. Such a write loads the written value, and bits set by hardware in the same cycle win.
- R8: Control bits 2i (local) and 2i+1 (global) enable slot i. `dbg_exc` is high for exactly the cycle after an event cycle in which an enabled slot hits. Several hits give one pulse. Hits on slots with both enables clear give none.
- R9: `task_switch` clears the local enables (bits 0, 2, 4, 6) and the local-exact bit 8 at the next edge. The global enables, the global-exact bit 9 and the other fields are kept. The clear also applies on top of a control write in the same cycle.
- R10: While guard bit 13 of control is set, a register write is dropped and status bit 13 is set. `dbg_exc` pulses in the next cycle and the guard bit clears so the handler can proceed. Reads are unaffected.
- R11: `step_strobe` sets status bit 14 and `ttrap_strobe` sets status bit 15, without raising `dbg_exc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx`, combinational |
| ev_valid | input | 1 | Access event present this cycle |
| ev_addr | input | 32 | Linear start address of the access |
| ev_size | input | 2 | Access size: 00 byte, 01 two bytes, 1x four bytes |
| ev_kind | input | 2 | Access kind: 00 fetch, 01 read, 10 write, 11 I/O |
| task_switch | input | 1 | Task-switch strobe, clears local enables |
| step_strobe | input | 1 | Single-step cause, sets status bit 14 |
| ttrap_strobe | input | 1 | Task-trap cause, sets status bit 15 |
| dbg_exc | output | 1 | One-cycle debug exception pulse |

## Verification
Matching is combinational, but status bits and `dbg_exc` are registered. Both are due one clock edge after the cycle that holds the event, the write or the strobe. Register reads are combinational and valid in the cycle `reg_idx` is driven. The bench drives every input one time unit after a rising edge and samples `dbg_exc` one time unit after the next edge, which is the only cycle it may be high. It then reads status back in that same cycle. For multi-hit and guarded-write cases it checks one more cycle to confirm that the pulse has dropped.

// File: rtl/brkpt_pkg.sv
// Package: shared encodings and register layout for the breakpoint unit.
// Assumes a 32-bit register port and exactly four breakpoint slots in the
// control layout (4 bits of type/length per slot starting at bit 16).
package brkpt_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_READ  = 2'b01,
        KIND_WRITE = 2'b10,
        KIND_IO    = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        TYPE_FETCH = 2'b00,
        TYPE_WRITE = 2'b01,
        TYPE_IO    = 2'b10,
        TYPE_DATA  = 2'b11
    } bp_type_e;

    typedef enum logic [1:0] {
        LEN_ONE  = 2'b00,
        LEN_TWO  = 2'b01,
        LEN_RSVD = 2'b10,
        LEN_FOUR = 2'b11
    } bp_len_e;

    localparam int REG_W       = 32;
    localparam int IDX_W       = 3;
    localparam int IDX_STATUS  = 6;
    localparam int IDX_CTRL    = 7;

    localparam int CTRL_LEXACT = 8;
    localparam int CTRL_GEXACT = 9;
    localparam int CTRL_GUARD  = 13;
    localparam int CTRL_CFG_LSB = 16;
    localparam int CFG_STRIDE  = 4;

    localparam int STAT_GUARD  = 13;
    localparam int STAT_STEP   = 14;
    localparam int STAT_TTRAP  = 15;

    localparam logic [REG_W-1:0] CTRL_KEEP  = 32'hFFFF_23FF;
    localparam logic [REG_W-1:0] STAT_KEEP  = 32'h0000_E00F;
    localparam logic [REG_W-1:0] LOCAL_BITS = 32'h0000_0155;
    localparam logic [REG_W-1:0] GLOBAL_BITS = 32'h0000_02AA;

endpackage

// File: rtl/brkpt_match.sv
// Module: one breakpoint comparator.
// Decides whether the current access touches this slot's byte window and
// is of a kind the slot watches. Purely combinational; the caller gates the
// result with the event-valid strobe. Windows do not wrap past 2^AW.
module brkpt_match
    import brkpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] bp_addr,
    input  logic [1:0]    cfg_type,
    input  logic [1:0]    cfg_len,
    input  logic [AW-1:0] ev_addr,
    input  logic [1:0]    ev_size,
    input  logic [1:0]    ev_kind,
    output logic          hit
);

    logic [AW-1:0] win_span;
    logic [AW:0]   win_lo, win_hi, acc_lo, acc_hi;
    logic [1:0]    acc_extra;
    logic          kind_ok, overlap;

    // Window span minus one from the length field (also the ignored low bits).
    always_comb begin
        win_span = '0;
        unique case (cfg_len)
            LEN_TWO:  win_span = AW'(1);
            LEN_FOUR: win_span = AW'(3);
            default:  win_span = '0;
        endcase
    end

    // Extra bytes past the access start address from the size code.
    always_comb begin
        unique case (ev_size)
            2'b00:   acc_extra = 2'd0;
            2'b01:   acc_extra = 2'd1;
            default: acc_extra = 2'd3;
        endcase
    end

    // Inclusive byte ranges in AW+1 bits so the end never wraps.
    always_comb begin
        win_lo = {1'b0, bp_addr & ~win_span};
        win_hi = win_lo + {1'b0, win_span};
        acc_lo = {1'b0, ev_addr};
        acc_hi = acc_lo + (AW+1)'(acc_extra);
        overlap = (acc_lo <= win_hi) && (win_lo <= acc_hi);
    end

    // Access kinds accepted by the type field.
    always_comb begin
        unique case (cfg_type)
            TYPE_FETCH: kind_ok = (ev_kind == KIND_FETCH);
            TYPE_WRITE: kind_ok = (ev_kind == KIND_WRITE);
            TYPE_IO:    kind_ok = (ev_kind == KIND_IO);
            default:    kind_ok = (ev_kind == KIND_READ) || (ev_kind == KIND_WRITE);
        endcase
    end

    // Final decision: reserved length never hits, fetch needs exact byte match.
    always_comb begin
        if (cfg_len == LEN_RSVD) begin
            hit = 1'b0;
        end else if (cfg_type == TYPE_FETCH) begin
            hit = kind_ok && (cfg_len == LEN_ONE) && (ev_addr == bp_addr);
        end else begin
            hit = kind_ok && overlap;
        end
    end

endmodule

// File: rtl/brkpt_regs.sv
// Module: register file of the breakpoint unit.
// Holds the slot addresses, the control word and the sticky status word,
// serves the indexed read/write port, applies the task-switch clear and the
// write guard, and decodes per-slot configuration for the comparators.
// Assumes hit_vld is already qualified by the event-valid strobe.
module brkpt_regs
    import brkpt_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int DW     = REG_W,
    parameter int IW     = IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_we,
    input  logic [IW-1:0]               reg_idx,
    input  logic [DW-1:0]               reg_wdata,
    output logic [DW-1:0]               reg_rdata,
    input  logic [NUM_BP-1:0]           hit_vld,
    input  logic                        task_switch,
    input  logic                        step_strobe,
    input  logic                        ttrap_strobe,
    output logic [NUM_BP-1:0][DW-1:0]   bp_addr_o,
    output logic [NUM_BP-1:0][1:0]      cfg_type_o,
    output logic [NUM_BP-1:0][1:0]      cfg_len_o,
    output logic [NUM_BP-1:0]           en_o,
    output logic                        guard_trap_o
);

    localparam int SEL_W = (NUM_BP > 1) ? $clog2(NUM_BP) : 1;

    logic [NUM_BP-1:0][DW-1:0] bp_q;
    logic [DW-1:0] ctrl_q, ctrl_nxt;
    logic [DW-1:0] stat_q, stat_nxt;
    logic          wr_ok, guard_trap, ctrl_load, stat_load;

    // Write qualification against the guard bit.
    always_comb begin
        guard_trap = reg_we && ctrl_q[CTRL_GUARD];
        wr_ok      = reg_we && !ctrl_q[CTRL_GUARD];
        ctrl_load  = wr_ok && (reg_idx == IW'(IDX_CTRL));
        stat_load  = wr_ok && (reg_idx == IW'(IDX_STATUS));
    end

    // Breakpoint address registers, one per slot.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_BP; gi++) begin : g_bp
            // Load slot address on an accepted write to its index.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bp_q[gi] <= '0;
                end else if (wr_ok && (reg_idx == IW'(gi))) begin
                    bp_q[gi] <= reg_wdata;
                end
            end
            assign cfg_type_o[gi] = ctrl_q[CTRL_CFG_LSB + CFG_STRIDE*gi     +: 2];
            assign cfg_len_o[gi]  = ctrl_q[CTRL_CFG_LSB + CFG_STRIDE*gi + 2 +: 2];
            assign en_o[gi]       = ctrl_q[2*gi] | ctrl_q[2*gi + 1];
        end
    endgenerate

    // Next control word: write, then guard release, then task-switch clear.
    always_comb begin
        ctrl_nxt = ctrl_q;
        if (ctrl_load) begin
            ctrl_nxt = reg_wdata & CTRL_KEEP;
        end
        if (guard_trap) begin
            ctrl_nxt[CTRL_GUARD] = 1'b0;
        end
        if (task_switch) begin
            ctrl_nxt = ctrl_nxt & ~LOCAL_BITS;
        end
    end

    // Next status word: software load, then hardware causes ORed on top.
    always_comb begin
        stat_nxt = stat_q;
        if (stat_load) begin
            stat_nxt = reg_wdata & STAT_KEEP;
        end
        stat_nxt[NUM_BP-1:0] = stat_nxt[NUM_BP-1:0] | hit_vld;
        if (guard_trap)   stat_nxt[STAT_GUARD] = 1'b1;
        if (step_strobe)  stat_nxt[STAT_STEP]  = 1'b1;
        if (ttrap_strobe) stat_nxt[STAT_TTRAP] = 1'b1;
    end

    // Control and status state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            ctrl_q <= ctrl_nxt;
            stat_q <= stat_nxt;
        end
    end

    // Read mux; unmapped indices return zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_idx < IW'(NUM_BP)) begin
            reg_rdata = bp_q[reg_idx[SEL_W-1:0]];
        end else if (reg_idx == IW'(IDX_STATUS)) begin
            reg_rdata = stat_q;
        end else if (reg_idx == IW'(IDX_CTRL)) begin
            reg_rdata = ctrl_q;
        end
    end

    assign bp_addr_o    = bp_q;
    assign guard_trap_o = guard_trap;

    // R7
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(stat_load) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));

    // R9
    task_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (task_switch && !reg_we) |=> (((ctrl_q & LOCAL_BITS) == '0) &&
            ((ctrl_q & GLOBAL_BITS) == ($past(ctrl_q) & GLOBAL_BITS))));

    // R10
    guard_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && ctrl_q[CTRL_GUARD]) |=> (stat_q[STAT_GUARD] && !ctrl_q[CTRL_GUARD] &&
            (bp_q == $past(bp_q))));

    // R2
    unused_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !task_switch && ((reg_idx == IW'(4)) || (reg_idx == IW'(5)))) |=>
            ((bp_q == $past(bp_q)) && (ctrl_q == $past(ctrl_q))));

endmodule

// File: rtl/brkpt_exc.sv
// Module: debug exception pulse generator.
// Registers one pulse for a cycle in which any enabled slot hit or a guarded
// register write was attempted. Assumes hit_vld is qualified by event valid.
module brkpt_exc #(
    parameter int NUM_BP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_BP-1:0] hit_vld,
    input  logic [NUM_BP-1:0] en_vec,
    input  logic              guard_trap,
    output logic              dbg_exc
);

    logic exc_q;

    // One registered pulse per qualifying cycle, many hits folded to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_q <= 1'b0;
        end else begin
            exc_q <= (|(hit_vld & en_vec)) || guard_trap;
        end
    end

    assign dbg_exc = exc_q;

endmodule

// File: rtl/brkpt_watch_unit.sv
// Module: top of the hardware address breakpoint unit.
// Instantiates the register file, one comparator per slot and the exception
// pulse generator. Matching uses the register values present in the event
// cycle; results show in status and dbg_exc one edge later.
module brkpt_watch_unit
    import brkpt_pkg::*;
#(
    parameter int NUM_BP = 4,
    parameter int DW     = REG_W,
    parameter int IW     = IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [IW-1:0] reg_idx,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ev_valid,
    input  logic [DW-1:0] ev_addr,
    input  logic [1:0]    ev_size,
    input  logic [1:0]    ev_kind,
    input  logic          task_switch,
    input  logic          step_strobe,
    input  logic          ttrap_strobe,
    output logic          dbg_exc
);

    logic [NUM_BP-1:0][DW-1:0] bp_addr;
    logic [NUM_BP-1:0][1:0]    cfg_type, cfg_len;
    logic [NUM_BP-1:0]         en_vec, hit_raw, hit_vld;
    logic                      guard_trap;

    brkpt_regs #(.NUM_BP(NUM_BP), .DW(DW), .IW(IW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_idx      (reg_idx),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .hit_vld      (hit_vld),
        .task_switch  (task_switch),
        .step_strobe  (step_strobe),
        .ttrap_strobe (ttrap_strobe),
        .bp_addr_o    (bp_addr),
        .cfg_type_o   (cfg_type),
        .cfg_len_o    (cfg_len),
        .en_o         (en_vec),
        .guard_trap_o (guard_trap)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_BP; gi++) begin : g_cmp
            brkpt_match #(.AW(DW)) u_match (
                .bp_addr  (bp_addr[gi]),
                .cfg_type (cfg_type[gi]),
                .cfg_len  (cfg_len[gi]),
                .ev_addr  (ev_addr),
                .ev_size  (ev_size),
                .ev_kind  (ev_kind),
                .hit      (hit_raw[gi])
            );

            // R3
            rsvd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_len[gi] == LEN_RSVD) |-> !hit_raw[gi]);

            // R5
            fetch_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (hit_raw[gi] && (ev_kind == KIND_FETCH)) |->
                    ((ev_addr == bp_addr[gi]) && (cfg_len[gi] == LEN_ONE)));
        end
    endgenerate

    assign hit_vld = hit_raw & {NUM_BP{ev_valid}};

    brkpt_exc #(.NUM_BP(NUM_BP)) u_exc (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_vld    (hit_vld),
        .en_vec     (en_vec),
        .guard_trap (guard_trap),
        .dbg_exc    (dbg_exc)
    );

    // R8
    exc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_exc |-> $past(ev_valid || reg_we));

    // R8
    exc_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && |(hit_raw & en_vec)) |=> dbg_exc);

    // R11
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid && !reg_we) |=> !dbg_exc);

endmodule

// File: tb/brkpt_watch_unit_tb.sv
// Bench: directed corner cases then seeded random traffic, all checked
// against a register model kept in the bench.
module brkpt_watch_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h1000_0040;
    localparam logic [31:0] CMASK = 32'hFFFF_23FF;
    localparam logic [31:0] SMASK = 32'h0000_E00F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_valid = 1'b0;
    logic [31:0] ev_addr = '0;
    logic [1:0]  ev_size = '0;
    logic [1:0]  ev_kind = '0;
    logic        task_switch = 1'b0;
    logic        step_strobe = 1'b0;
    logic        ttrap_strobe = 1'b0;
    logic        dbg_exc;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;

    logic [31:0] m_bp [4];
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_stat = '0;

    brkpt_watch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
        .ev_addr(ev_addr), .ev_size(ev_size), .ev_kind(ev_kind),
        .task_switch(task_switch), .step_strobe(step_strobe),
        .ttrap_strobe(ttrap_strobe), .dbg_exc(dbg_exc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] val);
        reg_idx = idx;
        #1;
        val = reg_rdata;
    endtask

    // Expected hit of slot i for one access, from the requirement text.
    function automatic bit exp_hit(int i, logic [31:0] a, logic [1:0] sz, logic [1:0] kd);
        logic [1:0] ty, ln;
        bit ok;
        longint blen, alen, bs, be, as_, ae;
        ty = m_ctrl[16 + 4*i +: 2];
        ln = m_ctrl[18 + 4*i +: 2];
        if (ln == 2'b10) return 1'b0;
        if (ty == 2'b00) return (kd == 2'b00) && (ln == 2'b00) && (a == m_bp[i]);
        case (ty)
            2'b01:   ok = (kd == 2'b10);
            2'b10:   ok = (kd == 2'b11);
            default: ok = (kd == 2'b01) || (kd == 2'b10);
        endcase
        blen = (ln == 2'b00) ? 1 : (ln == 2'b01) ? 2 : 4;
        alen = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
        bs  = longint'(m_bp[i]);
        bs  = bs - (bs % blen);
        be  = bs + blen - 1;
        as_ = longint'(a);
        ae  = as_ + alen - 1;
        return ok && (as_ <= be) && (bs <= ae);
    endfunction

    // Register write with model update; checks the exception from the guard.
    task automatic wr(input logic [2:0] idx, input logic [31:0] d, input string tag);
        bit trap;
        trap = m_ctrl[13];
        reg_we = 1'b1; reg_idx = idx; reg_wdata = d;
        tick();
        reg_we = 1'b0;
        if (trap) begin
            m_stat[13] = 1'b1;
            m_ctrl[13] = 1'b0;
        end else begin
            if (idx < 3'd4) m_bp[idx] = d;
            else if (idx == 3'd6) m_stat = d & SMASK;
            else if (idx == 3'd7) m_ctrl = d & CMASK;
        end
        chk({tag, " R10 exc on write"}, {31'b0, dbg_exc}, {31'b0, trap});
    endtask

    // One access event; checks the pulse and the status word one edge later.
    task automatic ev(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] kd,
                      input string tag);
        logic [3:0] h;
        logic [31:0] v;
        bit x;
        for (int i = 0; i < 4; i++) h[i] = exp_hit(i, a, sz, kd);
        x = 1'b0;
        for (int i = 0; i < 4; i++) x |= h[i] && (m_ctrl[2*i] || m_ctrl[2*i+1]);
        ev_valid = 1'b1; ev_addr = a; ev_size = sz; ev_kind = kd;
        tick();
        ev_valid = 1'b0;
        chk({tag, " R8 exc"}, {31'b0, dbg_exc}, {31'b0, x});
        m_stat[3:0] = m_stat[3:0] | h;
        rd(3'd6, v);
        chk({tag, " R7 status"}, v, m_stat);
    endtask

    function automatic logic [31:0] cfg(int i, logic [1:0] ty, logic [1:0] ln);
        return {28'b0, ln, ty} << (16 + 4*i);
    endfunction

    logic [31:0] v;
    int unsigned seed_sink;

    initial begin
        for (int i = 0; i < 4; i++) m_bp[i] = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            chk("R1 reset reg", v, 32'h0);
        end
        chk("R1 reset exc", {31'b0, dbg_exc}, 32'h0);

        // R2 register map
        wr(3'd0, 32'hA5A5_0001, "R2");
        wr(3'd1, 32'h5A5A_FFFE, "R2");
        wr(3'd4, 32'hFFFF_FFFF, "R2");
        rd(3'd4, v); chk("R2 idx4 reads zero", v, 32'h0);
        rd(3'd5, v); chk("R2 idx5 reads zero", v, 32'h0);
        rd(3'd0, v); chk("R2 bp0 readback", v, 32'hA5A5_0001);
        rd(3'd1, v); chk("R2 bp1 readback", v, 32'h5A5A_FFFE);
        wr(3'd7, 32'hFFFF_DFFF, "R2");
        rd(3'd7, v); chk("R2 ctrl mask", v, 32'hFFFF_03FF);
        wr(3'd7, 32'h0, "R2");

        // R3 length windows
        wr(3'd0, BASE + 1, "R3");
        wr(3'd7, cfg(0, 2'b11, 2'b01) | 32'h1, "R3");
        ev(BASE, 2'b00, 2'b01, "R3 word masked hit");
        rd(3'd6, v); chk("R3 word hit B0", v & 32'hF, 32'h1);
        wr(3'd6, 32'h0, "R3");
        ev(BASE + 2, 2'b00, 2'b01, "R3 word miss");
        wr(3'd0, BASE + 3, "R3");
        wr(3'd7, cfg(0, 2'b11, 2'b11) | 32'h1, "R3");
        ev(BASE, 2'b00, 2'b10, "R3 dword low byte");
        ev(BASE + 4, 2'b00, 2'b10, "R3 dword next miss");
        wr(3'd6, 32'h0, "R3");
        wr(3'd7, cfg(0, 2'b11, 2'b10) | 32'h1, "R3");
        ev(BASE + 3, 2'b00, 2'b01, "R3 reserved len");
        rd(3'd6, v); chk("R3 reserved no status", v, 32'h0);

        // R6 straddling access
        wr(3'd1, BASE + 32'h10, "R6");
        wr(3'd7, cfg(1, 2'b01, 2'b00) | 32'h8, "R6");
        ev(BASE + 32'hE, 2'b11, 2'b10, "R6 straddle dword");
        rd(3'd6, v); chk("R6 straddle B1", v, 32'h2);
        ev(BASE + 32'hE, 2'b01, 2'b10, "R6 word short");

        // R4 access types
        wr(3'd6, 32'h0, "R4");
        ev(BASE + 32'h10, 2'b00, 2'b01, "R4 write-only vs read");
        wr(3'd2, BASE + 32'h20, "R4");
        wr(3'd3, BASE + 32'h30, "R4");
        wr(3'd7, cfg(2, 2'b10, 2'b00) | cfg(3, 2'b11, 2'b00) | 32'hF0, "R4");
        ev(BASE + 32'h20, 2'b00, 2'b11, "R4 io hit");
        ev(BASE + 32'h20, 2'b00, 2'b10, "R4 io vs write");
        ev(BASE + 32'h30, 2'b00, 2'b01, "R4 data read");
        ev(BASE + 32'h30, 2'b00, 2'b00, "R4 data vs fetch");
        rd(3'd6, v); chk("R4 status B2 B3", v, 32'hC);

        // R5 fetch breakpoints
        wr(3'd6, 32'h0, "R5");
        wr(3'd0, BASE + 32'h31, "R5");
        wr(3'd7, cfg(0, 2'b00, 2'b00) | 32'h2, "R5");
        ev(BASE + 32'h31, 2'b11, 2'b00, "R5 fetch exact");
        ev(BASE + 32'h30, 2'b11, 2'b00, "R5 fetch near miss");
        ev(BASE + 32'h31, 2'b00, 2'b01, "R5 read vs fetch bp");
        wr(3'd7, cfg(0, 2'b00, 2'b01) | 32'h2, "R5");
        ev(BASE + 32'h31, 2'b00, 2'b00, "R5 fetch with len 01");

        // R8 enables and multi-hit
        wr(3'd6, 32'h0, "R8");
        for (int i = 0; i < 4; i++) wr(3'(i), BASE + 32'h40, "R8");
        wr(3'd7, cfg(0, 2'b11, 2'b00) | cfg(1, 2'b11, 2'b00) |
                 cfg(2, 2'b11, 2'b00) | cfg(3, 2'b11, 2'b00), "R8");
        ev(BASE + 32'h40, 2'b00, 2'b01, "R8 disabled hits");
        rd(3'd6, v); chk("R8 status without enable", v, 32'hF);
        wr(3'd6, 32'h0, "R8");
        wr(3'd7, m_ctrl | 32'hAA, "R8");
        ev(BASE + 32'h40, 2'b00, 2'b10, "R8 four hits");
        tick();
        chk("R8 single pulse", {31'b0, dbg_exc}, 32'h0);

        // R7 sticky status
        repeat (3) tick();
        rd(3'd6, v); chk("R7 sticky", v, 32'hF);
        wr(3'd6, 32'h0, "R7");
        rd(3'd6, v); chk("R7 cleared by write", v, 32'h0);

        // R9 task switch
        wr(3'd7, (m_ctrl & 32'hFFFF_0000) | 32'h3FF, "R9");
        task_switch = 1'b1;
        tick();
        task_switch = 1'b0;
        m_ctrl = m_ctrl & ~32'h155;
        rd(3'd7, v); chk("R9 locals cleared", v, m_ctrl);
        chk("R9 globals kept", v & 32'h2AA, 32'h2AA);

        // R11 strobes
        step_strobe = 1'b1;
        tick();
        step_strobe = 1'b0;
        chk("R11 step no exc", {31'b0, dbg_exc}, 32'h0);
        ttrap_strobe = 1'b1;
        tick();
        ttrap_strobe = 1'b0;
        chk("R11 ttrap no exc", {31'b0, dbg_exc}, 32'h0);
        rd(3'd6, v); chk("R11 status", v, 32'h0000_C000);

        // R10 guarded write
        wr(3'd7, m_ctrl | 32'h2000, "R10");
        rd(3'd0, v);
        wr(3'd0, 32'hDEAD_BEEF, "R10 guarded");
        rd(3'd0, v); chk("R10 write dropped", v, m_bp[0]);
        rd(3'd6, v); chk("R10 BD set", v, 32'h0000_E000);
        rd(3'd7, v); chk("R10 guard released", v & 32'h2000, 32'h0);
        tick();
        chk("R10 pulse drops", {31'b0, dbg_exc}, 32'h0);
        wr(3'd6, 32'h0, "R10");

        // Random traffic against the model
        seed_sink = $urandom(32'd7331);
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom % 100;
            if (r < 6) begin
                wr(3'($urandom % 4), BASE + ($urandom % 64), "R2 rand");
            end else if (r < 10) begin
                wr(3'd7, $urandom & ~32'h2000, "R2 rand");
            end else if (r < 14) begin
                wr(3'd6, 32'h0, "R7 rand");
            end else if (r < 16) begin
                task_switch = 1'b1;
                tick();
                task_switch = 1'b0;
                m_ctrl = m_ctrl & ~32'h155;
                rd(3'd7, v); chk("R9 rand", v, m_ctrl);
            end else begin
                ev(BASE - 4 + ($urandom % 80), 2'($urandom), 2'($urandom), "R6 rand");
            end
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule